// File: doc/BRIEF.md
# Clock Loss Frequency Monitor

This block watches the two clocks that feed a phase-frequency detector, the reference clock and the feedback clock. It confirms that both keep running above a minimum rate. A free-running monitor clock times a window of programmable length. Within each window the block counts the rising edges of each watched clock. Each watched clock toggles a flop in its own domain, and that toggle is synchronised into the monitor domain.

When a window closes and either count is below a fixed minimum, the block raises a loss flag. The flag is sticky: it stays up after the clock comes back, until software pulses the clear input or reset is applied. The monitor runs only while its enable input is high and the clock system is in PLL mode. In external clock mode the monitor is forced off. The first window after each activation is discarded so that the counters and synchronisers can settle.

Top module: `clk_loss_mon`

## Requirements
- R1: After reset, `loss_flag` is 0.
- R2: The monitor is active only while `enable`=1 and `ext_mode`=0. While it is inactive, the window and the counts restart, and `loss_flag` is never set, even with both watched clocks stopped.
- R3: `ext_mode`=1 disables the monitor whatever the value of `enable`.
- R4: One window lasts `window_len`+1 monitor-clock cycles, counted from the first monitor edge at which the block is active.
- R5: At the close of an evaluated window, if the rising-edge count of either watched clock is below `MIN_TOGGLES`, `loss_flag` is set at that same monitor edge.
- R6: The first window after each activation is not evaluated. With a clock stopped from the moment of activation, `loss_flag` rises at the end of the second window (2×(`window_len`+1) cycles) and not earlier.
- R7: `loss_flag` stays 1 after the lost clock recovers, until `clear` or reset.
- R8: A one-cycle `clear` pulse drops `loss_flag` at the next monitor edge. If a loss is declared at that same edge, the set wins.
- R9: The reference and feedback clocks are judged independently. Losing either one alone sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Always-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Watched reference clock |
| fb_clk | input | 1 | Watched feedback clock |
| enable | input | 1 | Monitor enable |
| ext_mode | input | 1 | 1 = external clock mode, monitor forced off |
| clear | input | 1 | Flag clear strobe (monitor domain) |
| window_len | input | WIN_W | Window length minus one, in monitor cycles |
| loss_flag | output | 1 | Sticky loss-of-clock flag |

## Verification
The hardest case to reach from the ports is the settle rule. The first window after activation must stay silent even with a dead clock, and the flag must rise exactly at the end of the second window. The stimulus stops the reference clock before asserting enable. It then samples the flag halfway through the second window and halfway through the third. Random trials vary the window length and the half-periods of both clocks. Half-periods are drawn only from ranges well clear of the threshold, so the expected outcome is unambiguous despite the asynchronous edge phases.

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
  parameter int WIN_W       = 16,
  parameter int CNT_W       = 12,
  parameter int MIN_TOGGLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             mon_clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             fb_clk,
  input  logic             enable,
  input  logic             ext_mode,
  input  logic             clear,
  input  logic [WIN_W-1:0] window_len,
  output logic             loss_flag
);
  localparam int SL = SYNC_STAGES;
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_TOGGLES);

  logic           tgl_ref, tgl_fb;
  logic [SL:0]    sy_ref, sy_fb;
  logic           hit_ref, hit_fb;
  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] cnt_ref, cnt_fb, nxt_ref, nxt_fb;
  logic           active, win_end, armed, loss_evt;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) tgl_ref <= 1'b0;
    else        tgl_ref <= ~tgl_ref;

  always_ff @(posedge fb_clk or negedge rst_n)
    if (!rst_n) tgl_fb <= 1'b0;
    else        tgl_fb <= ~tgl_fb;

  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n) begin
      sy_ref <= '0;
      sy_fb  <= '0;
    end else begin
      sy_ref <= {sy_ref[SL-1:0], tgl_ref};
      sy_fb  <= {sy_fb[SL-1:0], tgl_fb};
    end

  assign hit_ref = sy_ref[SL] ^ sy_ref[SL-1];
  assign hit_fb  = sy_fb[SL]  ^ sy_fb[SL-1];

  assign active  = enable & ~ext_mode;
  assign win_end = active && (win_cnt >= window_len);

  assign nxt_ref = (&cnt_ref) ? cnt_ref : cnt_ref + CNT_W'(hit_ref);
  assign nxt_fb  = (&cnt_fb)  ? cnt_fb  : cnt_fb  + CNT_W'(hit_fb);

  assign loss_evt = win_end && armed && ((nxt_ref < MIN_C) || (nxt_fb < MIN_C));

  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0;
      cnt_ref <= '0;
      cnt_fb  <= '0;
      armed   <= 1'b0;
    end else if (!active) begin
      win_cnt <= '0;
      cnt_ref <= '0;
      cnt_fb  <= '0;
      armed   <= 1'b0;
    end else if (win_end) begin
      win_cnt <= '0;
      cnt_ref <= '0;
      cnt_fb  <= '0;
      armed   <= 1'b1;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      cnt_ref <= nxt_ref;
      cnt_fb  <= nxt_fb;
    end

  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n)        loss_flag <= 1'b0;
    else if (loss_evt) loss_flag <= 1'b1;
    else if (clear)    loss_flag <= 1'b0;

endmodule

// File: rtl/clk_loss_mon_chk.sv
module clk_loss_mon_chk (
  input logic mon_clk,
  input logic rst_n,
  input logic enable,
  input logic ext_mode,
  input logic clear,
  input logic loss_flag,
  input logic win_end,
  input logic armed
);
  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge mon_clk) disable iff (!rst_n)
    loss_flag && !clear |=> loss_flag); // R7
  AST_OFF_NO_SET: assert property (@(posedge mon_clk) disable iff (!rst_n)
    !loss_flag && (ext_mode || !enable) |=> !loss_flag); // R2
  AST_EXT_OFF: assert property (@(posedge mon_clk) disable iff (!rst_n)
    ext_mode |-> !win_end); // R3
  AST_CLEAR_DROPS: assert property (@(posedge mon_clk) disable iff (!rst_n)
    clear && !win_end |=> !loss_flag); // R8
  AST_SET_ONLY_ARMED: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $rose(loss_flag) |-> $past(win_end && armed)); // R6
endmodule

bind clk_loss_mon clk_loss_mon_chk u_chk (.*);

// File: tb/clk_loss_mon_tb.sv
`timescale 1ns/1ps
module clk_loss_mon_tb;
  localparam int MIN = 4;

  logic mon_clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, fb_clk = 1'b0;
  logic enable = 1'b0, ext_mode = 1'b0, clear = 1'b0;
  logic [15:0] window_len = 16'd49;
  logic loss_flag;

  bit ref_run = 1'b1, fb_run = 1'b1;
  int ref_half = 40, fb_half = 40;
  int n_vec = 0, n_bad = 0;

  clk_loss_mon #(.MIN_TOGGLES(MIN)) u_dut (.*);

  always #10 mon_clk = ~mon_clk;
  always begin
    if (ref_run) begin #(ref_half); ref_clk = ~ref_clk; end
    else #10;
  end
  always begin
    if (fb_run) begin #(fb_half); fb_clk = ~fb_clk; end
    else #10;
  end

  function automatic int toggles(bit run, int half, int w);
    return run ? (w * 20) / (2 * half) : 0;
  endfunction

  function automatic bit exp_loss(bit rr, int rh, bit fr, int fh, int w);
    return (toggles(rr, rh, w) < MIN) || (toggles(fr, fh, w) < MIN);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: loss_flag=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge mon_clk);
    @(negedge mon_clk);
  endtask

  task automatic pulse_clear();
    @(negedge mon_clk); clear = 1'b1;
    @(negedge mon_clk); clear = 1'b0;
  endtask

  task automatic setup(int wl, bit rr, int rh, bit fr, int fh);
    @(negedge mon_clk);
    enable = 1'b0; ext_mode = 1'b0;
    window_len = 16'(wl);
    ref_run = rr; ref_half = rh; fb_run = fr; fb_half = fh;
    cyc(100);
    pulse_clear();
  endtask

  int seed;
  initial begin
    seed = $urandom(20240611);
    cyc(3);
    chk("R1", loss_flag, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", loss_flag, 1'b0);

    // R2: disabled with both clocks stopped
    setup(49, 0, 40, 0, 40);
    cyc(300);
    chk("R2", loss_flag, 1'b0);

    // R3: enabled in external clock mode with both clocks stopped
    enable = 1'b1; ext_mode = 1'b1;
    cyc(300);
    chk("R3", loss_flag, 1'b0);

    // R6 and R4: settle window, flag at end of second window (W=50)
    setup(49, 0, 40, 1, 40);
    enable = 1'b1;
    cyc(75);
    chk("R6", loss_flag, 1'b0);
    cyc(50);
    chk("R4", loss_flag, 1'b1);

    // R7: sticky after the clock recovers
    ref_run = 1'b1;
    cyc(300);
    chk("R7", loss_flag, 1'b1);

    // R8: clear with healthy clocks
    pulse_clear();
    chk("R8", loss_flag, 1'b0);
    cyc(300);
    chk("R8", loss_flag, 1'b0);

    // R8 and R5: clear while the loss persists, flag returns
    ref_run = 1'b0;
    cyc(200);
    pulse_clear();
    cyc(110);
    chk("R5", loss_flag, 1'b1);

    // R9: only the feedback clock lost
    setup(49, 1, 40, 0, 40);
    enable = 1'b1;
    cyc(250);
    chk("R9", loss_flag, 1'b1);

    // R5: slow but running reference
    setup(63, 1, 700, 1, 40);
    enable = 1'b1;
    cyc(330);
    chk("R5", loss_flag, 1'b1);

    // Random trials, R5 and R9
    for (int t = 0; t < 24; t++) begin
      int wl, w, kind, rh, fh;
      bit rr, fr, e;
      wl = 40 + int'($urandom % 80);
      w = wl + 1;
      kind = int'($urandom % 4);
      rr = 1'b1; fr = 1'b1;
      rh = 30 + int'($urandom % ((w * 20) / 24 - 29));
      fh = 30 + int'($urandom % ((w * 20) / 24 - 29));
      if (kind == 1) begin
        if ($urandom % 2) rr = 1'b0; else rh = w * 10 + int'($urandom % 100);
      end else if (kind == 2) begin
        if ($urandom % 2) fr = 1'b0; else fh = w * 10 + int'($urandom % 100);
      end
      e = exp_loss(rr, rh, fr, fh, w);
      setup(wl, rr, rh, fr, fh);
      enable = 1'b1;
      cyc(5 * w);
      chk(kind == 2 ? "R9" : "R5", loss_flag, e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule